// File: doc/BRIEF.md
# Codec Response Ring Dispatcher

This block sits between a codec link receiver and the host side of an audio controller. Each 64-bit response that arrives from the link, a 32-bit response word plus a 32-bit extended word, is written into a 256-entry circular ring. A consumer stage then drains the ring one entry per cycle, in arrival order. It uses the extended word to decide where each entry goes. Unsolicited events leave through a valid/ready event output. Solicited responses are matched against a per-codec count of outstanding commands. Entries that cannot be matched are dropped and reported on a spurious pulse.

The command path reports each command it issues to a codec with a one-cycle pulse tagged by the codec address. The block keeps one outstanding count and one last-response word per codec, and a status query port exposes both. A small register window enables the ring and the interrupt, sets the number of entries per interrupt, clears the interrupt status and resets the write pointer.

Top module: `rsp_ring_top`

## Requirements
- R1: While reception is enabled, each `rspValid` pulse stores `{rspExt, rspData}` at the write pointer plus one. The write pointer, readable at register 3 bits 7:0, advances modulo 256, so the first entry after a reset lands at index 1.
- R2: Entries are dispatched in arrival order, one per cycle. Bits 3:0 of the extended word give the codec address and bit 4 marks the entry as unsolicited.
- R3: An unsolicited entry with a valid address is presented on `evtData` as `{ext, rsp}` with `evtValid` high. It holds until `evtReady` is high and leaves every outstanding count unchanged.
- R4: A solicited entry for a codec whose count is non-zero becomes that codec's last response, and the count drops by one.
- R5: A solicited entry for a codec whose count is zero raises `spurious` for one cycle and changes no count and no last response.
- R6: An entry whose address is at or above `NUM_CODECS` (default 4) raises `spurious` and produces no event, whatever bit 4 holds.
- R7: A `cmdIssue` pulse raises its codec's count by one, saturating at 15. An issue and a matched response for the same codec in the same cycle leave the count unchanged.
- R8: Register 1 bits 7:0 (reset value 1) set the number of accepted entries per interrupt, and a value of 0 never interrupts. When the count is reached, status bit 0 (register 2) sets and the entry count restarts. Writing 1 to that bit clears it. `irq` equals the status bit ANDed with control bit 1 (register 0).
- R9: While control bit 0 (register 0) is clear, incoming responses are dropped: the write pointer does not move, nothing is dispatched and no interrupt counting happens.
- R10: A write to register 3 with bit 15 set returns the write pointer, the consumer's read index and the interrupt entry count to zero.
- R11: After reset `irq`, `evtValid` and `spurious` are low, registers 0, 2 and 3 read 0, register 1 reads 1, and every count is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| rspValid | input | 1 | Response strobe from the link |
| rspData | input | 32 | Response word |
| rspExt | input | 32 | Extended word (address, unsolicited flag) |
| cmdIssue | input | 1 | Command issued pulse |
| cmdAddr | input | 4 | Codec address of the issued command |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 2 | Register index |
| regWrData | input | 16 | Register write data |
| regRdData | output | 16 | Register read data (combinational) |
| statAddr | input | 4 | Codec selected for the status query |
| statCount | output | 4 | Outstanding count of the selected codec |
| statResp | output | 32 | Last solicited response of the selected codec |
| evtValid | output | 1 | Unsolicited event available |
| evtReady | input | 1 | Event consumer ready |
| evtData | output | 64 | Event entry `{ext, rsp}` |
| spurious | output | 1 | One-cycle pulse per discarded entry |
| irq | output | 1 | Response interrupt |

## Verification
A response sampled at edge N is in the ring, has moved the write pointer and, when it completes the threshold, has set the interrupt status after edge N. Its dispatch happens at edge N+1: the count, the last response, the `spurious` pulse and the event output all change there. Register writes and command pulses take effect at the edge that samples them. The bench drives inputs two nanoseconds after a rising edge and reads results only after the edge on which they are due. A scoreboard queue holds the expected events, and a monitor compares them at falling edges when a handshake occurs and also tallies the spurious pulses.

// File: rtl/rsp_ring_pkg.sv
package rsp_ring_pkg;
  localparam int PTR_W      = 8;
  localparam int RING_DEPTH = 1 << PTR_W;
  localparam int WORD_W     = 32;
  localparam int ENTRY_W    = 2 * WORD_W;
  localparam int ADDR_W     = 4;
  localparam int UNSOL_BIT  = 4;
  localparam int REG_W      = 16;

  typedef struct packed {
    logic             wrEn;
    logic [PTR_W-1:0] wrIdx;
    logic             consume;
    logic [PTR_W-1:0] rdIdx;
  } ringStrobes_t;
endpackage

// File: rtl/rsp_ring_ctrl.sv
module rsp_ring_ctrl
  import rsp_ring_pkg::*;
(
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    rspValid,
  input  logic                    regWrEn,
  input  logic [1:0]              regAddr,
  input  logic [REG_W-1:0]        regWrData,
  output logic [REG_W-1:0]        regRdData,
  input  logic                    rdIsEvent,
  input  logic                    evtBusy,
  output ringStrobes_t            strb,
  output logic                    irq
);
  localparam int THR_W = 8;

  logic [PTR_W-1:0] wp, rp;
  logic [THR_W-1:0] entCnt, thresh;
  logic             dmaEn, irqEn, irqSts;
  logic             wpReset, accept, irqSet, stsClr;
  logic [PTR_W-1:0] wpNext;
  logic [THR_W-1:0] entNext;
  logic             unusedBits;

  assign wpReset = regWrEn && regAddr == 2'd3 && regWrData[15];
  assign stsClr  = regWrEn && regAddr == 2'd2 && regWrData[0];
  assign wpNext  = wp + PTR_W'(1);
  assign accept  = rspValid && dmaEn && !wpReset && (wpNext != rp);
  assign entNext = entCnt + THR_W'(1);
  assign irqSet  = accept && thresh != '0 && entNext == thresh;

  assign strb.wrEn    = accept;
  assign strb.wrIdx   = wpNext;
  assign strb.rdIdx   = rp + PTR_W'(1);
  assign strb.consume = dmaEn && !wpReset && (rp != wp) && !(rdIsEvent && evtBusy);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wp <= '0;
      rp <= '0;
      entCnt <= '0;
    end else if (wpReset) begin
      wp <= '0;
      rp <= '0;
      entCnt <= '0;
    end else begin
      if (accept) begin
        wp <= wpNext;
        entCnt <= irqSet ? '0 : entNext;
      end
      if (strb.consume) rp <= strb.rdIdx;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dmaEn  <= 1'b0;
      irqEn  <= 1'b0;
      thresh <= THR_W'(1);
      irqSts <= 1'b0;
    end else begin
      if (regWrEn && regAddr == 2'd0) begin
        dmaEn <= regWrData[0];
        irqEn <= regWrData[1];
      end
      if (regWrEn && regAddr == 2'd1) thresh <= regWrData[THR_W-1:0];
      if (irqSet) irqSts <= 1'b1;
      else if (stsClr) irqSts <= 1'b0;
    end
  end

  assign irq = irqSts && irqEn;

  always_comb begin
    regRdData = '0;
    case (regAddr)
      2'd0:    regRdData = {{(REG_W-2){1'b0}}, irqEn, dmaEn};
      2'd1:    regRdData = {{(REG_W-THR_W){1'b0}}, thresh};
      2'd2:    regRdData = {{(REG_W-1){1'b0}}, irqSts};
      default: regRdData = {{(REG_W-PTR_W){1'b0}}, wp};
    endcase
  end

  assign unusedBits = ^regWrData[14:THR_W];

  // R9: with reception off and no pointer reset the write pointer holds
  assert_dma_gate_R9: assert property (@(posedge clk) disable iff (!rstN)
    (!dmaEn && !wpReset) |=> $stable(wp));

  // R10: pointer reset clears both indices on the next cycle
  assert_ptr_reset_R10: assert property (@(posedge clk) disable iff (!rstN)
    wpReset |=> (wp == '0 && rp == '0));

  // R1: the ring never overruns the consumer
  assert_no_overrun_R1: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrEn |-> (strb.wrIdx != rp));
endmodule

// File: rtl/rsp_ring_datapath.sv
module rsp_ring_datapath
  import rsp_ring_pkg::*;
#(
  parameter int NUM_CODECS = 4,
  parameter int CNT_W      = 4
)(
  input  logic                 clk,
  input  logic                 rstN,
  input  ringStrobes_t         strb,
  input  logic [WORD_W-1:0]    rspData,
  input  logic [WORD_W-1:0]    rspExt,
  input  logic                 cmdIssue,
  input  logic [ADDR_W-1:0]    cmdAddr,
  input  logic [ADDR_W-1:0]    statAddr,
  output logic [CNT_W-1:0]     statCount,
  output logic [WORD_W-1:0]    statResp,
  output logic                 evtValid,
  input  logic                 evtReady,
  output logic [ENTRY_W-1:0]   evtData,
  output logic                 spurious,
  output logic                 rdIsEvent,
  output logic                 evtBusy
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [ENTRY_W-1:0]  ringMem [RING_DEPTH];
  logic [ENTRY_W-1:0]  entry;
  logic [ADDR_W-1:0]   rdAddr;
  logic                rdUnsol, rdInRange;
  logic [CNT_W-1:0]    cntArr  [NUM_CODECS];
  logic [WORD_W-1:0]   respArr [NUM_CODECS];
  logic [NUM_CODECS-1:0] zeroHit;

  always_ff @(posedge clk) begin
    if (strb.wrEn) ringMem[strb.wrIdx] <= {rspExt, rspData};
  end

  assign entry     = ringMem[strb.rdIdx];
  assign rdAddr    = entry[WORD_W +: ADDR_W];
  assign rdUnsol   = entry[WORD_W + UNSOL_BIT];
  assign rdInRange = int'(rdAddr) < NUM_CODECS;
  assign rdIsEvent = rdInRange && rdUnsol;
  assign evtBusy   = evtValid && !evtReady;

  for (genvar i = 0; i < NUM_CODECS; i++) begin : g_codec
    logic [CNT_W-1:0]  cntR;
    logic [WORD_W-1:0] respR;
    logic incI, selI, decI;

    assign incI = cmdIssue && cmdAddr == ADDR_W'(i);
    assign selI = strb.consume && !rdUnsol && rdAddr == ADDR_W'(i);
    assign decI = selI && cntR != '0;
    assign zeroHit[i] = selI && cntR == '0;

    always_ff @(posedge clk) begin
      if (!rstN) begin
        cntR  <= '0;
        respR <= '0;
      end else begin
        if (incI && !decI && cntR != CNT_MAX) cntR <= cntR + CNT_W'(1);
        else if (decI && !incI) cntR <= cntR - CNT_W'(1);
        if (decI) respR <= entry[WORD_W-1:0];
      end
    end

    assign cntArr[i]  = cntR;
    assign respArr[i] = respR;

    // R4: a matched response without a same-cycle issue lowers the count by one
    assert_count_dec_R4: assert property (@(posedge clk) disable iff (!rstN)
      (decI && !incI) |=> cntR == $past(cntR) - CNT_W'(1));

    // R7: a saturated count stays saturated on another issue
    assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rstN)
      (cntR == CNT_MAX && incI && !decI) |=> cntR == CNT_MAX);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      evtValid <= 1'b0;
      evtData  <= '0;
      spurious <= 1'b0;
    end else begin
      spurious <= strb.consume && (!rdInRange || |zeroHit);
      if (strb.consume && rdIsEvent) begin
        evtValid <= 1'b1;
        evtData  <= entry;
      end else if (evtReady) begin
        evtValid <= 1'b0;
      end
    end
  end

  always_comb begin
    statCount = '0;
    statResp  = '0;
    for (int i = 0; i < NUM_CODECS; i++) begin
      if (statAddr == ADDR_W'(i)) begin
        statCount = cntArr[i];
        statResp  = respArr[i];
      end
    end
  end

  // R3: a stalled event keeps its data
  assert_evt_hold_R3: assert property (@(posedge clk) disable iff (!rstN)
    (evtValid && !evtReady) |=> (evtValid && $stable(evtData)));

  // R5: a spurious pulse follows a dispatch by the control
  assert_spur_src_R5: assert property (@(posedge clk) disable iff (!rstN)
    spurious |-> $past(strb.consume));
endmodule

// File: rtl/rsp_ring_top.sv
module rsp_ring_top
  import rsp_ring_pkg::*;
#(
  parameter int NUM_CODECS = 4,
  parameter int CNT_W      = 4
)(
  input  logic                clk,
  input  logic                rstN,
  input  logic                rspValid,
  input  logic [WORD_W-1:0]   rspData,
  input  logic [WORD_W-1:0]   rspExt,
  input  logic                cmdIssue,
  input  logic [ADDR_W-1:0]   cmdAddr,
  input  logic                regWrEn,
  input  logic [1:0]          regAddr,
  input  logic [REG_W-1:0]    regWrData,
  output logic [REG_W-1:0]    regRdData,
  input  logic [ADDR_W-1:0]   statAddr,
  output logic [CNT_W-1:0]    statCount,
  output logic [WORD_W-1:0]   statResp,
  output logic                evtValid,
  input  logic                evtReady,
  output logic [ENTRY_W-1:0]  evtData,
  output logic                spurious,
  output logic                irq
);
  ringStrobes_t strb;
  logic rdIsEvent, evtBusy;

  rsp_ring_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .rspValid(rspValid),
    .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData),
    .regRdData(regRdData), .rdIsEvent(rdIsEvent), .evtBusy(evtBusy),
    .strb(strb), .irq(irq)
  );

  rsp_ring_datapath #(.NUM_CODECS(NUM_CODECS), .CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .rspData(rspData), .rspExt(rspExt),
    .cmdIssue(cmdIssue), .cmdAddr(cmdAddr), .statAddr(statAddr),
    .statCount(statCount), .statResp(statResp), .evtValid(evtValid),
    .evtReady(evtReady), .evtData(evtData), .spurious(spurious),
    .rdIsEvent(rdIsEvent), .evtBusy(evtBusy)
  );
endmodule

// File: tb/rsp_ring_top_bench.sv
module rsp_ring_top_bench;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic rspValid = 1'b0;
  logic [31:0] rspData = '0, rspExt = '0;
  logic cmdIssue = 1'b0;
  logic [3:0] cmdAddr = '0;
  logic regWrEn = 1'b0;
  logic [1:0] regAddr = '0;
  logic [15:0] regWrData = '0;
  logic [15:0] regRdData;
  logic [3:0] statAddr = '0;
  logic [3:0] statCount;
  logic [31:0] statResp;
  logic evtValid, evtReady = 1'b1, spurious, irq;
  logic [63:0] evtData;

  int checks = 0, failures = 0;
  int spurSeen = 0, expSpur = 0;
  logic [63:0] expQ[$];

  always #4 clk = ~clk;

  rsp_ring_top u_rsp_ring_top (
    .clk(clk), .rstN(rstN), .rspValid(rspValid), .rspData(rspData),
    .rspExt(rspExt), .cmdIssue(cmdIssue), .cmdAddr(cmdAddr),
    .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData),
    .regRdData(regRdData), .statAddr(statAddr), .statCount(statCount),
    .statResp(statResp), .evtValid(evtValid), .evtReady(evtReady),
    .evtData(evtData), .spurious(spurious), .irq(irq)
  );

  task automatic checkEq(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #2;
  endtask

  task automatic regWrite(input logic [1:0] a, input logic [15:0] d);
    tick(); regWrEn = 1'b1; regAddr = a; regWrData = d;
    tick(); regWrEn = 1'b0;
  endtask

  task automatic regRead(input logic [1:0] a, output logic [15:0] d);
    regAddr = a; #1; d = regRdData;
  endtask

  task automatic stat(input logic [3:0] a, output logic [3:0] c, output logic [31:0] r);
    statAddr = a; #1; c = statCount; r = statResp;
  endtask

  task automatic issue(input logic [3:0] a);
    tick(); cmdIssue = 1'b1; cmdAddr = a;
    tick(); cmdIssue = 1'b0;
  endtask

  task automatic sendRsp(input logic [31:0] d, input logic [31:0] e);
    tick(); rspValid = 1'b1; rspData = d; rspExt = e;
    tick(); rspValid = 1'b0;
    tick(); tick();
  endtask

  // monitor: pops expected events on each handshake, tallies spurious pulses
  always @(negedge clk) begin
    if (rstN && evtValid && evtReady) begin
      if (expQ.size() == 0) checkEq("R3 unexpected event", evtData, 64'h0);
      else checkEq("R3 event data", evtData, expQ.pop_front());
    end
    if (rstN && spurious) spurSeen++;
  end

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [15:0] rd;
    logic [3:0]  c;
    logic [31:0] r;
    logic [7:0]  wp0;

    repeat (3) tick();
    rstN = 1'b1;
    tick();

    // R11 reset state
    checkEq("R11 irq", irq, 0);
    checkEq("R11 evtValid", evtValid, 0);
    checkEq("R11 spurious", spurious, 0);
    regRead(0, rd); checkEq("R11 ctrl", rd, 0);
    regRead(1, rd); checkEq("R11 thresh", rd, 1);
    regRead(2, rd); checkEq("R11 status", rd, 0);
    regRead(3, rd); checkEq("R11 wptr", rd, 0);
    for (int i = 0; i < 4; i++) begin
      stat(i[3:0], c, r); checkEq("R11 count", c, 0);
    end

    regWrite(0, 16'h0003);

    // R7 issue increments
    issue(2); issue(2);
    stat(2, c, r); checkEq("R7 count after two issues", c, 2);

    // R4 matched response, R1 pointer, R8 interrupt at threshold 1
    sendRsp(32'hA5A5_0001, 32'h2);
    stat(2, c, r);
    checkEq("R4 count dec", c, 1);
    checkEq("R4 last resp", r, 32'hA5A5_0001);
    regRead(3, rd); checkEq("R1 wptr first index", rd, 1);
    checkEq("R8 irq on entry", irq, 1);
    regWrite(2, 16'h0001);
    checkEq("R8 w1c clears irq", irq, 0);

    // R3/R2 unsolicited routed to event output, counts untouched
    expQ.push_back({32'h0000_0011, 32'hBEEF_0002});
    sendRsp(32'hBEEF_0002, 32'h11);
    stat(1, c, r); checkEq("R3 count untouched", c, 0);
    stat(2, c, r); checkEq("R3 other count untouched", c, 1);

    // R5 response with zero count
    expSpur++;
    sendRsp(32'hDEAD_0003, 32'h3);
    stat(3, c, r);
    checkEq("R5 last resp unchanged", r, 0);
    checkEq("R5 count stays zero", c, 0);
    checkEq("R5 spurious seen", spurSeen, expSpur);

    // R6 out of range address, flag set, no event
    expSpur++;
    sendRsp(32'hCAFE_0004, 32'h19);
    checkEq("R6 spurious seen", spurSeen, expSpur);
    checkEq("R6 no event", evtValid, 0);

    // R7 simultaneous issue and match on codec 2
    tick(); rspValid = 1'b1; rspData = 32'h1234_0005; rspExt = 32'h2;
    tick(); rspValid = 1'b0; cmdIssue = 1'b1; cmdAddr = 2;
    tick(); cmdIssue = 1'b0;
    stat(2, c, r);
    checkEq("R7 simultaneous count", c, 1);
    checkEq("R4 simultaneous resp", r, 32'h1234_0005);
    sendRsp(32'h1234_0006, 32'h2);
    stat(2, c, r); checkEq("R4 count to zero", c, 0);

    // R7 saturation
    for (int i = 0; i < 20; i++) issue(1);
    stat(1, c, r); checkEq("R7 saturates", c, 15);

    // R8 threshold of 3
    regWrite(2, 16'h0001);
    regWrite(1, 16'h0003);
    expSpur += 2;
    sendRsp(32'h1, 32'h3); sendRsp(32'h2, 32'h3);
    checkEq("R8 no irq before threshold", irq, 0);
    expSpur++;
    sendRsp(32'h3, 32'h3);
    checkEq("R8 irq at threshold", irq, 1);
    regWrite(2, 16'h0001);
    // R8 interrupt enable gates irq but not status
    regWrite(0, 16'h0001);
    expSpur += 3;
    sendRsp(32'h4, 32'h3); sendRsp(32'h5, 32'h3); sendRsp(32'h6, 32'h3);
    checkEq("R8 irq masked", irq, 0);
    regRead(2, rd); checkEq("R8 status set while masked", rd, 1);
    regWrite(2, 16'h0001);
    regRead(2, rd); checkEq("R8 status cleared", rd, 0);

    // R9 reception disabled
    regWrite(0, 16'h0000);
    regRead(3, rd); wp0 = rd[7:0];
    sendRsp(32'h7, 32'h3);
    regRead(3, rd); checkEq("R9 wptr unchanged", rd, {8'h0, wp0});
    checkEq("R9 no dispatch", spurSeen, expSpur);
    regRead(2, rd); checkEq("R9 no status", rd, 0);

    // R3 back-pressure, order kept
    regWrite(0, 16'h0003);
    evtReady = 1'b0;
    sendRsp(32'h1111_0008, 32'h10);
    sendRsp(32'h2222_0009, 32'h10);
    checkEq("R3 valid held", evtValid, 1);
    checkEq("R3 first data held", evtData, {32'h10, 32'h1111_0008});
    tick(); tick();
    checkEq("R3 data stable", evtData, {32'h10, 32'h1111_0008});
    expQ.push_back({32'h10, 32'h1111_0008});
    expQ.push_back({32'h10, 32'h2222_0009});
    evtReady = 1'b1;
    repeat (5) tick();
    checkEq("R3 queue drained", expQ.size(), 0);
    checkEq("R2 event output empty", evtValid, 0);

    // R1 wrap modulo 256 with back-to-back responses
    regWrite(1, 16'h0000);
    regRead(3, rd); wp0 = rd[7:0];
    tick(); rspValid = 1'b1; rspData = 32'h9; rspExt = 32'h3;
    repeat (260) tick();
    rspValid = 1'b0;
    repeat (4) tick();
    expSpur += 260;
    regRead(3, rd); checkEq("R1 wptr wraps", rd, {8'h0, 8'(wp0 + 8'd4)});
    checkEq("R2 all dispatched", spurSeen, expSpur);
    checkEq("R8 threshold zero never", irq, 0);

    // R10 pointer reset
    regWrite(3, 16'h8000);
    regRead(3, rd); checkEq("R10 wptr reset", rd, 0);
    expSpur++;
    sendRsp(32'hA, 32'h3);
    regRead(3, rd); checkEq("R10 first index after reset", rd, 1);
    checkEq("R10 single dispatch", spurSeen, expSpur);

    checkEq("R3 scoreboard empty", expQ.size(), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule